// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit holds a 64-bit vector-state word and applies a single "configure vector length" operation to it. Each operation picks a new maximum vector length (MVL) and a new active vector length (VL). MVL comes from a small immediate or keeps its stored value. VL comes from one of four sources: the stored value, a general register, the immediate, or a 64-bit loop counter. A source that does not fit in seven bits saturates to 127. The chosen VL is then clamped to the new MVL. Either event raises a one-cycle overflow flag.

The unit can also write the result to a destination register. When the destination index is nonzero, it issues a one-cycle write strobe carrying VL zero-extended to 64 bits. If vertical-first is requested while neither set-VL nor set-MVL is asked for, the operation becomes an element-step query. In that case the externally supplied step value goes to the destination, and the state word is left alone.

An operation is requested with a one-cycle `op_valid` strobe. The state word updates on that clock edge, and every output is registered.

Top module: `vlcfg_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the state word, overflow flag, write strobe and write data all become zero.
- R2: The immediate length is `imm + 1` modulo 128, so an immediate of 127 gives 0. When `mode_ms` is 1, MVL takes the immediate length. Otherwise MVL keeps its stored value.
- R3: When `mode_vs` is 0 in a non-query operation, the candidate VL is the stored VL.
- R4: When `mode_vs` is 1 and `src_is_zero` is 0, the candidate VL is `src_val[6:0]`. If `src_val` is above 127 as an unsigned number, the candidate is 127 and overflow is raised.
- R5: When `mode_vs` is 1 and both `src_is_zero` and `dst_is_zero` are 1, the candidate VL is the immediate length.
- R6: When `mode_vs` is 1, `src_is_zero` is 1 and `dst_is_zero` is 0, the candidate VL comes from `ctr_val` and saturates at 127 the same way as in R4. A counter of exactly 127 raises no overflow.
- R7: A candidate VL above the new MVL (unsigned) is replaced by MVL and raises overflow. It follows that `vl_o` never exceeds `mvl_o`.
- R8: One cycle after an operation with `dst_is_zero` equal to 0, `dst_we_o` is 1. In a non-query operation, `dst_data_o` then holds the new VL zero-extended. No write strobe follows an operation with `dst_is_zero` equal to 1.
- R9: The vertical-first bit takes `mode_vf` and the persistence bit is cleared only when `mode_vs` or `mode_ms` is 1. Otherwise both bits are kept.
- R10: When `mode_vf` is 1 and both `mode_vs` and `mode_ms` are 0, the operation is a query. `dst_data_o` is `step_in` zero-extended, the state word does not change, and no overflow is raised.
- R11: In a cycle after `op_valid` was 0, the state word is unchanged and `dst_we_o` and `ovf_o` are 0, whatever the other inputs hold.
- R12: The state word uses MSB-0 numbering, with MVL in bits 0-6, VL in bits 7-13, persistence in bit 62 and vertical-first in bit 63. In LSB-0 terms on `state_o` these are [63:57], [56:50], [1] and [0]. No operation changes any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle operation strobe |
| imm | input | 7 | Immediate length minus one |
| src_val | input | 64 | Source register value |
| src_is_zero | input | 1 | Source register index is zero |
| dst_is_zero | input | 1 | Destination register index is zero |
| ctr_val | input | 64 | Loop counter value |
| mode_vf | input | 1 | Vertical-first request |
| mode_vs | input | 1 | Set-VL request |
| mode_ms | input | 1 | Set-MVL request |
| step_in | input | 7 | Element step value for query operations |
| state_o | output | 64 | Whole vector-state word |
| mvl_o | output | 7 | Stored maximum vector length |
| vl_o | output | 7 | Stored vector length |
| vf_o | output | 1 | Vertical-first bit |
| persist_o | output | 1 | Persistence bit |
| ovf_o | output | 1 | Overflow of the last operation |
| dst_we_o | output | 1 | Destination write strobe |
| dst_data_o | output | 64 | Destination write data |

## Verification
The bench uses the default widths: a 7-bit length field and a 64-bit register and counter. With these widths, every saturation edge can be driven directly. This includes counter values of 127, 128 and far above 2^32, and a register value just above the field limit. The immediate wrap at 127 and the largest MVL of 127 are also in reach. The clamp is exercised both by a large register value and by shrinking MVL below a retained VL.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int LEN_W   = 7;
  localparam int XLEN    = 64;
  localparam int STATE_W = 64;
  localparam int LEN_MAX = (1 << LEN_W) - 1;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             sat;
  } len_pick_t;

  // immediate length: value plus one, wrapping in the field width
  function automatic logic [LEN_W-1:0] imm_len(input logic [LEN_W-1:0] v);
    return v + LEN_W'(1);
  endfunction

  // squeeze a wide value into the length field, flagging saturation
  function automatic len_pick_t squeeze(input logic [XLEN-1:0] v);
    len_pick_t r;
    if (v[XLEN-1:LEN_W] != '0) begin
      r.len = LEN_W'(LEN_MAX);
      r.sat = 1'b1;
    end else begin
      r.len = v[LEN_W-1:0];
      r.sat = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] zext(input logic [LEN_W-1:0] v);
    return {{(XLEN-LEN_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/vlcfg_vl_select.sv
module vlcfg_vl_select
  import vlcfg_pkg::*;
(
  input  logic             set_vl,
  input  logic             src_is_zero,
  input  logic             dst_is_zero,
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [LEN_W-1:0] imm_length,
  input  logic [LEN_W-1:0] cur_vl,
  input  logic [LEN_W-1:0] new_mvl,
  output logic [LEN_W-1:0] vl_out,
  output logic             sat_evt,
  output logic             clamp_evt
);
  len_pick_t from_src, from_ctr;
  logic [LEN_W-1:0] cand;

  assign from_src = squeeze(src_val);
  assign from_ctr = squeeze(ctr_val);

  always_comb begin
    cand    = cur_vl;
    sat_evt = 1'b0;
    if (set_vl) begin
      if (!src_is_zero) begin
        cand    = from_src.len;
        sat_evt = from_src.sat;
      end else if (dst_is_zero) begin
        cand    = imm_length;
      end else begin
        cand    = from_ctr.len;
        sat_evt = from_ctr.sat;
      end
    end
  end

  assign clamp_evt = cand > new_mvl;
  assign vl_out    = clamp_evt ? new_mvl : cand;
endmodule

// File: rtl/vlcfg_state_reg.sv
module vlcfg_state_reg
  import vlcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_len,
  input  logic               wr_mode,
  input  logic [LEN_W-1:0]   mvl_d,
  input  logic [LEN_W-1:0]   vl_d,
  input  logic               vf_d,
  output logic [STATE_W-1:0] word_q,
  output logic [LEN_W-1:0]   mvl_q,
  output logic [LEN_W-1:0]   vl_q,
  output logic               vf_q,
  output logic               persist_q
);
  // MSB-0 field positions mapped onto LSB-0 indices
  localparam int MVL_HI  = STATE_W - 1;
  localparam int MVL_LO  = STATE_W - LEN_W;
  localparam int VL_HI   = MVL_LO - 1;
  localparam int VL_LO   = MVL_LO - LEN_W;
  localparam int PER_BIT = 1;
  localparam int VF_BIT  = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else begin
      if (wr_len) begin
        word_q[MVL_HI:MVL_LO] <= mvl_d;
        word_q[VL_HI:VL_LO]   <= vl_d;
      end
      if (wr_mode) begin
        word_q[VF_BIT]  <= vf_d;
        word_q[PER_BIT] <= 1'b0;
      end
    end
  end

  assign mvl_q     = word_q[MVL_HI:MVL_LO];
  assign vl_q      = word_q[VL_HI:VL_LO];
  assign vf_q      = word_q[VF_BIT];
  assign persist_q = word_q[PER_BIT];
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [LEN_W-1:0]   imm,
  input  logic [XLEN-1:0]    src_val,
  input  logic               src_is_zero,
  input  logic               dst_is_zero,
  input  logic [XLEN-1:0]    ctr_val,
  input  logic               mode_vf,
  input  logic               mode_vs,
  input  logic               mode_ms,
  input  logic [LEN_W-1:0]   step_in,
  output logic [STATE_W-1:0] state_o,
  output logic [LEN_W-1:0]   mvl_o,
  output logic [LEN_W-1:0]   vl_o,
  output logic               vf_o,
  output logic               persist_o,
  output logic               ovf_o,
  output logic               dst_we_o,
  output logic [XLEN-1:0]    dst_data_o
);
  // named internal events, visible to the bound checker
  logic             is_query;
  logic             cfg_op;
  logic             mode_wr;
  logic             sat_evt;
  logic             clamp_evt;
  logic [LEN_W-1:0] imm_length;
  logic [LEN_W-1:0] mvl_next;
  logic [LEN_W-1:0] vl_next;

  assign is_query   = mode_vf & ~mode_vs & ~mode_ms;
  assign cfg_op     = op_valid & ~is_query;
  assign mode_wr    = cfg_op & (mode_vs | mode_ms);
  assign imm_length = imm_len(imm);
  assign mvl_next   = mode_ms ? imm_length : mvl_o;

  vlcfg_vl_select u_sel (
    .set_vl      (mode_vs),
    .src_is_zero (src_is_zero),
    .dst_is_zero (dst_is_zero),
    .src_val     (src_val),
    .ctr_val     (ctr_val),
    .imm_length  (imm_length),
    .cur_vl      (vl_o),
    .new_mvl     (mvl_next),
    .vl_out      (vl_next),
    .sat_evt     (sat_evt),
    .clamp_evt   (clamp_evt)
  );

  vlcfg_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_len    (cfg_op),
    .wr_mode   (mode_wr),
    .mvl_d     (mvl_next),
    .vl_d      (vl_next),
    .vf_d      (mode_vf),
    .word_q    (state_o),
    .mvl_q     (mvl_o),
    .vl_q      (vl_o),
    .vf_q      (vf_o),
    .persist_q (persist_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o      <= 1'b0;
      dst_we_o   <= 1'b0;
      dst_data_o <= '0;
    end else begin
      ovf_o    <= cfg_op & (sat_evt | clamp_evt);
      dst_we_o <= op_valid & ~dst_is_zero;
      if (op_valid && !dst_is_zero)
        dst_data_o <= is_query ? zext(step_in) : zext(vl_next);
    end
  end
endmodule

// File: rtl/vlcfg_checker.sv
module vlcfg_checker
  import vlcfg_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               op_valid,
  input logic               dst_is_zero,
  input logic               mode_vs,
  input logic               mode_ms,
  input logic               is_query,
  input logic               sat_evt,
  input logic               clamp_evt,
  input logic [STATE_W-1:0] state_o,
  input logic [LEN_W-1:0]   mvl_o,
  input logic [LEN_W-1:0]   vl_o,
  input logic               vf_o,
  input logic               ovf_o,
  input logic               dst_we_o,
  input logic [XLEN-1:0]    dst_data_o
);
  a_r7_vl_within_mvl: assert property (@(posedge clk) disable iff (rst)
    vl_o <= mvl_o);

  a_r7_r4_flag_raised: assert property (@(posedge clk) disable iff (rst)
    op_valid && !is_query && (sat_evt || clamp_evt) |=> ovf_o);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(state_o) && !dst_we_o && !ovf_o);

  a_r10_query_keeps_state: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_query |=> $stable(state_o) && !ovf_o);

  a_r8_write_strobe: assert property (@(posedge clk) disable iff (rst)
    op_valid && !dst_is_zero |=> dst_we_o);

  a_r8_write_data: assert property (@(posedge clk) disable iff (rst)
    op_valid && !is_query && !dst_is_zero |=> dst_data_o == zext(vl_o));

  a_r9_mode_bits_kept: assert property (@(posedge clk) disable iff (rst)
    op_valid && !mode_vs && !mode_ms && !is_query |=> $stable(vf_o));
endmodule

bind vlcfg_unit vlcfg_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .dst_is_zero (dst_is_zero),
  .mode_vs     (mode_vs),
  .mode_ms     (mode_ms),
  .is_query    (is_query),
  .sat_evt     (sat_evt),
  .clamp_evt   (clamp_evt),
  .state_o     (state_o),
  .mvl_o       (mvl_o),
  .vl_o        (vl_o),
  .vf_o        (vf_o),
  .ovf_o       (ovf_o),
  .dst_we_o    (dst_we_o),
  .dst_data_o  (dst_data_o)
);

// File: tb/vlcfg_unit_tb.sv
module vlcfg_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [6:0]  imm = '0;
  logic [63:0] src_val = '0;
  logic        src_is_zero = 1'b1;
  logic        dst_is_zero = 1'b1;
  logic [63:0] ctr_val = '0;
  logic        mode_vf = 1'b0, mode_vs = 1'b0, mode_ms = 1'b0;
  logic [6:0]  step_in = '0;
  logic [63:0] state_o, dst_data_o;
  logic [6:0]  mvl_o, vl_o;
  logic        vf_o, persist_o, ovf_o, dst_we_o;

  always #4 clk = ~clk;

  vlcfg_unit u_dut (.*);

  typedef struct {
    int          mvl, vl, vf, ovf, we;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int m_mvl = 0, m_vl = 0, m_vf = 0;
  logic [63:0] m_data = '0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(bit v, int im, logic [63:0] src, bit sz, bit dz,
                       logic [63:0] ctr, bit f, bit s, bit m, int st, string tag);
    exp_t e;
    int ilen, nm, c;
    bit o;
    @(negedge clk);
    op_valid = v; imm = 7'(im); src_val = src; src_is_zero = sz;
    dst_is_zero = dz; ctr_val = ctr; mode_vf = f; mode_vs = s;
    mode_ms = m; step_in = 7'(st);
    e.tag = tag; e.ovf = 0; e.we = 0;
    if (v) begin
      e.we = !dz;
      if (f && !s && !m) begin
        if (!dz) m_data = 64'(st);
      end else begin
        ilen = (im + 1) % 128;
        nm = m ? ilen : m_mvl;
        o = 0;
        if (!s) c = m_vl;
        else if (!sz) begin
          if (src > 64'd127) begin c = 127; o = 1; end else c = int'(src);
        end else if (dz) c = ilen;
        else begin
          if (ctr > 64'd127) begin c = 127; o = 1; end else c = int'(ctr);
        end
        if (c > nm) begin c = nm; o = 1; end
        m_mvl = nm; m_vl = c; e.ovf = o;
        if (s || m) m_vf = f;
        if (!dz) m_data = 64'(c);
      end
    end
    e.mvl = m_mvl; e.vl = m_vl; e.vf = m_vf; e.data = m_data;
    q.push_back(e);
  endtask

  // monitor: samples after the edge that consumed the queued stimulus
  initial begin
    exp_t e;
    logic [63:0] word;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        word = (64'(e.mvl) << 57) | (64'(e.vl) << 50) | 64'(e.vf);
        chk(e.tag, "mvl", 64'(mvl_o), 64'(e.mvl));
        chk(e.tag, "vl", 64'(vl_o), 64'(e.vl));
        chk(e.tag, "ovf", 64'(ovf_o), 64'(e.ovf));
        chk(e.tag, "we", 64'(dst_we_o), 64'(e.we));
        chk(e.tag, "vf", 64'(vf_o), 64'(e.vf));
        chk(e.tag, "persist R9", 64'(persist_o), 64'd0);
        chk({e.tag, " R12"}, "state", state_o, word);
        if (e.we) chk(e.tag, "data", dst_data_o, e.data);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state, R11 idle
    drive(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R1_reset");
    // R2 set MVL from immediate, R3 retained VL
    drive(1, 15, 0, 1, 0, 0, 0, 0, 1, 0, "R2_mvl_imm");
    // R4 register source plain, saturated then clamped (R7)
    drive(1, 0, 64'd10, 0, 0, 0, 0, 1, 0, 0, "R4_src");
    drive(1, 0, 64'd200, 0, 0, 0, 0, 1, 0, 0, "R4_R7_src_sat");
    drive(1, 99, 64'd300, 0, 0, 0, 0, 1, 1, 0, "R4_R7_clamp100");
    drive(1, 0, 64'd128, 0, 1, 0, 0, 1, 0, 0, "R4_edge128_R8_nowrite");
    drive(1, 0, 64'd50, 0, 1, 0, 0, 1, 0, 0, "R8_dst_zero");
    // R5 immediate source
    drive(1, 20, 64'd999, 1, 1, 64'd999, 0, 1, 0, 0, "R5_imm_vl");
    // R6 counter source
    drive(1, 0, 0, 1, 0, 64'd70, 0, 1, 0, 0, "R6_ctr");
    drive(1, 0, 0, 1, 0, 64'h100_0000_0000, 0, 1, 0, 0, "R6_R7_ctr_big");
    drive(1, 126, 0, 1, 0, 64'd127, 0, 1, 1, 0, "R6_ctr127");
    drive(1, 0, 0, 1, 0, 64'd128, 0, 1, 0, 0, "R6_ctr128");
    // R3 with R7: shrink MVL below retained VL
    drive(1, 29, 0, 1, 0, 0, 0, 0, 1, 0, "R3_R7_shrink");
    // R9 vf set, then kept by a plain op
    drive(1, 29, 0, 1, 0, 0, 1, 0, 1, 0, "R9_vf_set");
    drive(1, 5, 64'd3, 0, 0, 0, 0, 0, 0, 0, "R9_R3_vf_kept");
    // R10 step query
    drive(1, 3, 64'd9, 0, 0, 0, 1, 0, 0, 77, "R10_query");
    drive(1, 3, 64'd9, 0, 1, 0, 1, 0, 0, 12, "R10_query_nodst");
    // R11 idle with busy inputs
    drive(0, 50, 64'd500, 0, 0, 64'd500, 1, 1, 1, 9, "R11_idle_busy");
    drive(0, 1, 64'd1, 1, 0, 64'd1, 0, 1, 1, 9, "R11_idle_busy2");
    // R9 vf cleared via vs
    drive(1, 0, 64'd4, 0, 0, 0, 0, 1, 0, 0, "R9_vf_clear");
    // R2 immediate wrap to zero
    drive(1, 127, 0, 1, 0, 0, 0, 0, 1, 0, "R2_wrap_R7");
    drive(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R11_tail");
    // R1 reset again from nonzero state
    drive(1, 40, 0, 1, 0, 0, 1, 0, 1, 0, "R2_reload");
    @(negedge clk);
    op_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    while (q.size() > 0) @(posedge clk);
    m_mvl = 0; m_vl = 0; m_vf = 0;
    drive(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R1_reset_again");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule